// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable integer N. It emits one pulse, one input cycle wide, for every N input cycles, and that pulse is meant to drive a phase detector. A two-modulus prescaler divides by P or by P+1. Behind it sit two down-counters. The swallow count A holds the prescaler at P+1 for the first A prescaler cycles of each output period. The main count B sets how many prescaler cycles make up the whole period. The resulting ratio is N = B·P + A.

A 2-bit select picks the base modulus P. The modulus-control line is brought out so that the prescaler's state can be watched. The A, B and select inputs are sampled at the end of each output period. Changing them partway through a period leaves that period at its full length.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While the active-low reset is held, `div_pulse_o` and `mod_ctl_o` are both 0.
- R2: Consecutive rising cycles of `div_pulse_o` are exactly B·P + A input clock cycles apart, using the A and B values that were sampled at the start of that period.
- R3: The select `psel_i` gives the base modulus as follows: 00 gives P=8, 01 gives P=16, 10 gives P=32 and 11 gives P=64. The prescaler then divides by P or by P+1.
- R4: In each output period, `mod_ctl_o` is high for exactly A·(P+1) input cycles, which are the first A prescaler cycles. It is low for the rest of the period, and it goes high only in the cycle in which the period starts.
- R5: With A = 0, the period is B·P cycles and `mod_ctl_o` stays low for the whole period.
- R6: `div_pulse_o` is high for exactly one input cycle per period.
- R7: The values of A, B and `psel_i` are sampled only on the clock edge that ends a period, which is the edge that raises `div_pulse_o`. A change made in the middle of a period does not alter that period's length.
- R8: The ratio holds at the limits of the counters: A = B, the largest A (63) and the largest B (4095).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_val_i | input | 6 | Swallow count A |
| b_val_i | input | 12 | Main count B |
| psel_i | input | 2 | Base modulus select |
| div_pulse_o | output | 1 | Divided output pulse, one cycle wide |
| mod_ctl_o | output | 1 | Prescaler modulus control (1 = divide by P+1) |

## Verification
The properties assume that the configuration always satisfies B ≥ A and B ≥ 3. Outside that range the ratio is not defined. The properties also assume that the inputs settle away from the clock edge.

The stimulus uses only settings that meet both limits, including the cases A = B, A = 0, B = 3 and the largest values of A and B. It changes settings on falling edges, either right after an output pulse or several cycles into a period. Every delay is kept shorter than the running period.

// File: rtl/psd_pkg.sv
package psd_pkg;
    localparam int unsigned A_WIDTH   = 6;
    localparam int unsigned B_WIDTH   = 12;
    localparam int unsigned SEL_WIDTH = 2;
    localparam int unsigned BASE_LOG2 = 3;

    typedef enum logic [1:0] {
        MOD_8  = 2'b00,
        MOD_16 = 2'b01,
        MOD_32 = 2'b10,
        MOD_64 = 2'b11
    } modsel_e;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int unsigned SEL_W   = psd_pkg::SEL_WIDTH,
    parameter int unsigned BASE_LG = psd_pkg::BASE_LOG2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             mod_hi_i,
    output logic             tick_o
);
    localparam int unsigned MAX_LG = BASE_LG + (1 << SEL_W) - 1;
    localparam int unsigned PC_W   = MAX_LG + 1;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PC_W-1:0] base_p;
    logic [PC_W-1:0] term;

    always_comb begin
        base_p = PC_W'(1) << (BASE_LG + 32'(sel_i));
        // last count of this prescaler cycle: P-1 or P
        term   = mod_hi_i ? base_p : base_p - PC_W'(1);
        tick_o = en_i && (s_q.pc == term);
        s_d    = s_q;
        if (!en_i) begin
            s_d.pc = '0;
        end else if (tick_o) begin
            s_d.pc = '0;
        end else begin
            s_d.pc = s_q.pc + PC_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr #(
    parameter int unsigned A_W   = psd_pkg::A_WIDTH,
    parameter int unsigned B_W   = psd_pkg::B_WIDTH,
    parameter int unsigned SEL_W = psd_pkg::SEL_WIDTH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [A_W-1:0]   a_i,
    input  logic [B_W-1:0]   b_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             tick_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             mod_o,
    output logic             pulse_o,
    output logic             init_o
);
    typedef struct packed {
        logic             init;
        logic [A_W-1:0]   a_left;
        logic [B_W-1:0]   b_left;
        logic [SEL_W-1:0] sel;
        logic             mod;
        logic             pulse;
    } ctr_state_t;

    ctr_state_t s_d, s_q;
    logic [A_W-1:0] a_dec;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        a_dec     = (s_q.a_left != '0) ? s_q.a_left - A_W'(1) : '0;
        if (s_q.init) begin
            // first load after reset, no output pulse
            s_d.init   = 1'b0;
            s_d.a_left = a_i;
            s_d.b_left = b_i;
            s_d.sel    = sel_i;
            s_d.mod    = (a_i != '0);
        end else if (tick_i) begin
            if (s_q.b_left == B_W'(1)) begin
                s_d.a_left = a_i;
                s_d.b_left = b_i;
                s_d.sel    = sel_i;
                s_d.mod    = (a_i != '0);
                s_d.pulse  = 1'b1;
            end else begin
                s_d.b_left = s_q.b_left - B_W'(1);
                s_d.a_left = a_dec;
                s_d.mod    = (a_dec != '0);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.init <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_o   = s_q.sel;
    assign mod_o   = s_q.mod;
    assign pulse_o = s_q.pulse;
    assign init_o  = s_q.init;
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
    parameter int unsigned A_W     = psd_pkg::A_WIDTH,
    parameter int unsigned B_W     = psd_pkg::B_WIDTH,
    parameter int unsigned SEL_W   = psd_pkg::SEL_WIDTH,
    parameter int unsigned BASE_LG = psd_pkg::BASE_LOG2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [A_W-1:0]   a_val_i,
    input  logic [B_W-1:0]   b_val_i,
    input  logic [SEL_W-1:0] psel_i,
    output logic             div_pulse_o,
    output logic             mod_ctl_o
);
    logic [SEL_W-1:0] sel_lat;
    logic             init_busy;
    logic             pre_tick;

    psd_prescaler #(
        .SEL_W   (SEL_W),
        .BASE_LG (BASE_LG)
    ) u_pre (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (!init_busy),
        .sel_i    (sel_lat),
        .mod_hi_i (mod_ctl_o),
        .tick_o   (pre_tick)
    );

    psd_swallow_ctr #(
        .A_W   (A_W),
        .B_W   (B_W),
        .SEL_W (SEL_W)
    ) u_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .a_i     (a_val_i),
        .b_i     (b_val_i),
        .sel_i   (psel_i),
        .tick_i  (pre_tick),
        .sel_o   (sel_lat),
        .mod_o   (mod_ctl_o),
        .pulse_o (div_pulse_o),
        .init_o  (init_busy)
    );
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int unsigned SEL_W = psd_pkg::SEL_WIDTH
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pulse_i,
    input logic             mod_i,
    input logic             tick_i,
    input logic             init_i,
    input logic [SEL_W-1:0] sel_lat_i
);
    // R1: outputs quiet while reset is applied
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            a_r1_reset_quiet: assert (!pulse_i && !mod_i);
        end
    end

    // R6: the output pulse never lasts two cycles
    a_r6_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_i |=> !pulse_i);

    // R4: modulus control only rises at a period start
    a_r4_mod_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mod_i) |-> (pulse_i || $past(init_i)));

    // R7: latched modulus select only moves at a period boundary
    a_r7_sel_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_lat_i != $past(sel_lat_i)) |-> (pulse_i || $past(init_i)));

    // R2: a period ends only on a prescaler tick
    a_r2_pulse_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pulse_i && !$past(init_i)) |-> $past(tick_i));
endmodule

bind pulse_swallow_divider psd_checker #(.SEL_W(SEL_W)) u_psd_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (div_pulse_o),
    .mod_i     (mod_ctl_o),
    .tick_i    (pre_tick),
    .init_i    (init_busy),
    .sel_lat_i (sel_lat)
);

// File: tb/tb_pulse_swallow_divider.sv
module tb_pulse_swallow_divider;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    n;
        int    hi;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  a_val = '0;
    logic [11:0] b_val = '0;
    logic [1:0]  psel = '0;
    logic        pulse;
    logic        mod;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    bit   finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_swallow_divider dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .a_val_i     (a_val),
        .b_val_i     (b_val),
        .psel_i      (psel),
        .div_pulse_o (pulse),
        .mod_ctl_o   (mod)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!pulse);
    endtask

    // R3 encoding: P = 8 << sel
    task automatic run(input int a, input int b, input int sel, input int reps,
                       input int delay, input string tag);
        int p;
        exp_t e;
        repeat (delay) @(negedge clk);
        a_val = 6'(a);
        b_val = 12'(b);
        psel  = 2'(sel);
        p = 8 << sel;
        for (int k = 0; k < reps; k++) begin
            wait_pulse();
            e.n   = b * p + a;
            e.hi  = a * (p + 1);
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    // monitor: measures each interval between pulses
    int cyc = 0;
    int hi = 0;
    bit have_prev = 0;
    bit prev_pulse = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pulse) begin
                check(!prev_pulse, "R6", 1, 0);
                if (have_prev) begin
                    exp_t e;
                    if (exp_q.size() == 0) begin
                        check(0, "R2", cyc, -1);
                    end else begin
                        e = exp_q.pop_front();
                        check(cyc == e.n, e.tag, cyc, e.n);
                        check(hi == e.hi, (e.hi == 0) ? "R5" : "R4", hi, e.hi);
                    end
                end
                have_prev = 1;
                cyc = 1;
                hi = mod ? 1 : 0;
            end else begin
                cyc++;
                if (mod) hi++;
            end
            prev_pulse = pulse;
        end
    end

    initial begin
        a_val = 6'd5;
        b_val = 12'd10;
        psel  = psd_pkg::MOD_8;
        repeat (3) begin
            @(negedge clk);
            check(pulse == 1'b0, "R1", int'(pulse), 0);
            check(mod == 1'b0, "R1", int'(mod), 0);
        end
        rst_n = 1'b1;
        run(5, 10, 0, 3, 0, "R2");      // 85
        run(0, 3, 0, 2, 0, "R5");       // 24, minimum B
        run(3, 3, 1, 2, 0, "R8");       // A = B, 51
        run(17, 200, 2, 1, 0, "R3");    // 6417
        run(63, 63, 3, 2, 0, "R8");     // largest A, 4095
        run(9, 12, 1, 2, 0, "R7");      // 201
        run(2, 5, 3, 2, 10, "R7");      // changed mid-period: 322
        run(40, 41, 0, 1, 7, "R7");     // 368
        run(1, 4095, 0, 1, 0, "R8");    // largest B, 32761
        wait_pulse();
        @(negedge clk);
        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        finished = 1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end
endmodule